// File: doc/BRIEF.md
# Variable-Length Instruction Stream Splitter

This block sits between an instruction fetch unit and a decoder. It accepts a stream of 32-bit little-endian fetch words and turns it into whole instructions that are either 16 or 32 bits wide. The block examines one halfword at a time. From the five top bits of a halfword it decides whether that halfword is a complete short instruction or the first half of a long one. It hands each instruction on together with a length flag and the address of its first halfword.

The instruction stream only needs halfword alignment. A long instruction can therefore begin in the upper half of one fetch word and end in the lower half of the next. When that happens, the block parks the first half in a one-halfword holding register and joins it with the following word. A redirect input sets a new halfword-aligned address, discards any parked halfword and drops the fetch word presented in that cycle. After a redirect, the fetch source supplies words starting at the word that contains the target address. The same input serves as the start address after reset.

Top module: `insn_splitter`

## Requirements
- R1: A halfword whose bits [15:11] are 5'b11101, 5'b11110 or 5'b11111 starts a 32-bit instruction, and `out_is32` is 1 for it. Any other value of bits [15:11] makes the halfword a whole 16-bit instruction, and `out_is32` is 0 for it.
- R2: A 16-bit instruction appears on `out_insn[15:0]`, with `out_insn[31:16]` equal to zero.
- R3: A 32-bit instruction that starts in the lower halfword (bits [15:0]) of a fetch word is output with that first halfword in `out_insn[31:16]` and the word's upper halfword (bits [31:16]) in `out_insn[15:0]`.
- R4: A 32-bit instruction that starts in the upper halfword of a fetch word is held back. It is output as {that halfword, lower halfword of the next fetch word}. The cycle that consumes the first word produces no output.
- R5: `out_addr` is the byte address of the instruction's first halfword. After each accepted instruction it advances by 2 for a 16-bit instruction and by 4 for a 32-bit instruction.
- R6: While `redirect_valid` is 1, `out_valid` is 0 and `fetch_ready` is 1, so the presented word is dropped. The next address becomes `redirect_addr` with bit 0 cleared, and any parked halfword is discarded. If bit 1 of the target is 1, the lower halfword of the next fetch word is skipped.
- R7: While `out_ready` is 0 and no redirect is requested, `fetch_ready` is 0. Every halfword of the stream reaches the output exactly once, in address order.
- R8: After reset, `out_addr` equals the parameter RESET_ADDR with bit 0 cleared, no halfword is parked, and `out_valid` is 0 while `fetch_valid` is 0.
- R9: A fetch word is accepted only in the cycle that uses its upper halfword: either it completes or issues a 16-bit or 32-bit instruction, or it is parked as the first half of a straddling instruction. `out_valid` needs `fetch_valid`, except in the parking cycle, where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_valid | input | 1 | Fetch word present |
| fetch_ready | output | 1 | Fetch word consumed this cycle |
| fetch_word | input | 32 | Fetch word, lower address in bits [15:0] |
| redirect_valid | input | 1 | Load a new stream address and flush |
| redirect_addr | input | ADDR_W | New stream address (bit 0 ignored) |
| out_valid | output | 1 | Instruction present |
| out_ready | input | 1 | Consumer takes the instruction |
| out_insn | output | 32 | Instruction, first halfword in the upper bits for 32-bit |
| out_is32 | output | 1 | 1 for a 32-bit instruction |
| out_addr | output | ADDR_W | Address of the instruction's first halfword |

## Verification
The stream under test is built from random halfwords, biased so that about 40% are long-instruction prefixes, after a directed prefix that covers all three long codes and the code just below them (5'b11100). This mix separates aligned long instructions from straddling ones and from short ones. Random gaps in `fetch_valid` and random `out_ready` back-pressure show whether a word is taken in the wrong cycle, which would lose or repeat a halfword. Redirects to random targets, including odd ones and ones at an upper halfword, some landing while a halfword is parked, check the flush, the skip of the lower halfword, and that bit 0 is ignored.

// File: rtl/insn_split_pkg.sv
// Package: shared constants and the length rule for the instruction splitter.
// Assumes halfwords of 16 bits and fetch words of two halfwords.
package insn_split_pkg;
    localparam int HW_W   = 16;
    localparam int LANES  = 2;
    localparam int WORD_W = HW_W * LANES;

    // True when the halfword is the leading half of a 32-bit instruction.
    function automatic logic starts_wide(input logic [HW_W-1:0] hw);
        return (hw[15:13] == 3'b111) && (hw[12:11] != 2'b00);
    endfunction
endpackage

// File: rtl/hw_len_detect.sv
// Module: classifies every halfword lane of a fetch word as a 32-bit prefix
// or not. Purely combinational; assumes lane 0 holds the lower address.
module hw_len_detect
    import insn_split_pkg::*;
#(
    parameter int N_LANES = LANES
) (
    input  logic [N_LANES*HW_W-1:0] word,
    output logic [N_LANES-1:0]      wide
);
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        // Length flag of one halfword lane.
        always_comb wide[g] = starts_wide(word[g*HW_W +: HW_W]);
    end
endmodule

// File: rtl/split_addr.sv
// Module: tracks the address of the next instruction to issue.
// Assumes advance pulses only on an accepted instruction; redirect wins.
module split_addr #(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              adv_is32,
    input  logic              redirect_valid,
    input  logic [ADDR_W-1:0] redirect_addr,
    output logic [ADDR_W-1:0] pc
);
    localparam logic [ADDR_W-1:0] HW_MASK = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] STEP2   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP4   = ADDR_W'(4);

    // Next-instruction address register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= RESET_ADDR & HW_MASK;
        else if (redirect_valid)
            pc <= redirect_addr & HW_MASK;
        else if (advance)
            pc <= pc + (adv_is32 ? STEP4 : STEP2);
    end

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !redirect_valid) |=>
            (pc == $past(pc) + ($past(adv_is32) ? STEP4 : STEP2)));

    assert_redirect_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (pc == ($past(redirect_addr) & HW_MASK)));

    assert_pc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !redirect_valid) |=> $stable(pc));
endmodule

// File: rtl/split_carry.sv
// Module: halfword selector and carry register. Chooses which halfword of
// the presented fetch word is next, forms the output instruction, parks a
// straddling first half, and decides when the fetch word is consumed.
// Assumes the fetch source holds a word stable until it is accepted.
module split_carry
    import insn_split_pkg::*;
#(
    parameter logic RESET_HI = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [WORD_W-1:0] fetch_word,
    input  logic [LANES-1:0]  wide,
    input  logic              out_ready,
    input  logic              redirect_valid,
    input  logic              redirect_hi,
    output logic              fetch_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_insn,
    output logic              out_is32
);
    logic            hw_sel;
    logic            hold_valid;
    logic [HW_W-1:0] hold_hw;
    logic [HW_W-1:0] lo_hw;
    logic [HW_W-1:0] hi_hw;
    logic            park;

    // Split the fetch word into its two lanes.
    always_comb begin
        lo_hw = fetch_word[HW_W-1:0];
        hi_hw = fetch_word[WORD_W-1:HW_W];
    end

    // A long instruction starting in the upper lane must be parked.
    always_comb park = !hold_valid && hw_sel && wide[1];

    // Output instruction formation.
    always_comb begin
        out_valid = fetch_valid && !redirect_valid && !park;
        if (hold_valid) begin
            out_insn = {hold_hw, lo_hw};
            out_is32 = 1'b1;
        end else if (hw_sel) begin
            out_insn = {{HW_W{1'b0}}, hi_hw};
            out_is32 = 1'b0;
        end else if (wide[0]) begin
            out_insn = {lo_hw, hi_hw};
            out_is32 = 1'b1;
        end else begin
            out_insn = {{HW_W{1'b0}}, lo_hw};
            out_is32 = 1'b0;
        end
    end

    // Fetch word consumption: only when its upper lane is used.
    always_comb begin
        if (redirect_valid)
            fetch_ready = 1'b1;
        else if (!out_ready || hold_valid)
            fetch_ready = 1'b0;
        else if (hw_sel)
            fetch_ready = 1'b1;
        else
            fetch_ready = wide[0];
    end

    // Lane pointer and carry register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_sel     <= RESET_HI;
            hold_valid <= 1'b0;
            hold_hw    <= '0;
        end else if (redirect_valid) begin
            hw_sel     <= redirect_hi;
            hold_valid <= 1'b0;
        end else if (fetch_valid && out_ready) begin
            if (hold_valid) begin
                hold_valid <= 1'b0;
                hw_sel     <= 1'b1;
            end else if (hw_sel) begin
                hw_sel <= 1'b0;
                if (wide[1]) begin
                    hold_valid <= 1'b1;
                    hold_hw    <= hi_hw;
                end
            end else if (!wide[0]) begin
                hw_sel <= 1'b1;
            end
        end
    end

    assert_hold_lower_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_valid |-> !hw_sel);

    assert_park_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready && park && !redirect_valid) |=> hold_valid);

    assert_no_accept_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_ready && !redirect_valid) |-> !fetch_ready);

    assert_redirect_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (!out_valid && fetch_ready));

    assert_redirect_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !hold_valid);
endmodule

// File: rtl/insn_splitter.sv
// Module: top of the variable-length instruction splitter. Turns a stream
// of little-endian fetch words into 16/32-bit instructions with addresses.
// Assumes that after a redirect the fetch source restarts at the word that
// contains the target address.
module insn_splitter
    import insn_split_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    output logic              fetch_ready,
    input  logic [31:0]       fetch_word,
    input  logic              redirect_valid,
    input  logic [ADDR_W-1:0] redirect_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_insn,
    output logic              out_is32,
    output logic [ADDR_W-1:0] out_addr
);
    logic [LANES-1:0] lane_wide;
    logic             accepted;

    // Handshake on the instruction port.
    always_comb accepted = out_valid && out_ready;

    hw_len_detect #(.N_LANES(LANES)) u_len (
        .word (fetch_word),
        .wide (lane_wide)
    );

    split_carry #(.RESET_HI(RESET_ADDR[1])) u_carry (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_valid    (fetch_valid),
        .fetch_word     (fetch_word),
        .wide           (lane_wide),
        .out_ready      (out_ready),
        .redirect_valid (redirect_valid),
        .redirect_hi    (redirect_addr[1]),
        .fetch_ready    (fetch_ready),
        .out_valid      (out_valid),
        .out_insn       (out_insn),
        .out_is32       (out_is32)
    );

    split_addr #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_addr (
        .clk            (clk),
        .rst_n          (rst_n),
        .advance        (accepted),
        .adv_is32       (out_is32),
        .redirect_valid (redirect_valid),
        .redirect_addr  (redirect_addr),
        .pc             (out_addr)
    );

    assert_short_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is32) |-> (out_insn[31:16] == 16'h0000));
endmodule

// File: tb/test_insn_splitter.sv
`timescale 1ns/1ps
module test_insn_splitter;
    localparam int          MEMH   = 1024;
    localparam logic [31:0] BASE   = 32'h0000_1000;
    localparam logic [31:0] LIMIT  = BASE + 2*MEMH - 64;
    localparam int          CYCLES = 6000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic        fetch_ready;
    logic [31:0] fetch_word = '0;
    logic        redirect_valid = 1'b0;
    logic [31:0] redirect_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_insn;
    logic        out_is32;
    logic [31:0] out_addr;

    int nchk = 0;
    int nfail = 0;

    logic [15:0] mem [0:MEMH-1];
    logic [31:0] fa, exp_pc, tgt, e_insn;
    logic        e_is32, e_valid, e_fr, redir;

    always #2 clk = ~clk;

    insn_splitter #(.ADDR_W(32), .RESET_ADDR(32'h0)) i_insn_splitter (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_word(fetch_word),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_insn(out_insn), .out_is32(out_is32), .out_addr(out_addr)
    );

    function automatic logic [15:0] hw_at(input logic [31:0] a);
        logic [31:0] idx = (a - BASE) >> 1;
        if (a < BASE || idx >= MEMH) return 16'h0000;
        return mem[idx];
    endfunction

    function automatic logic is_long(input logic [15:0] hw);
        return hw[15:11] == 5'b11101 || hw[15:11] == 5'b11110 || hw[15:11] == 5'b11111;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    initial begin
        #(4.0 * 200000);
        nfail++;
        $display("FAIL R7 watchdog expired act=%0d exp=%0d", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEMH; i++) begin
            logic [15:0] h = 16'($urandom);
            if ($urandom % 5 < 2) h[15:11] = 5'b11101 + 5'($urandom % 3);
            else if (is_long(h)) h[15] = 1'b0;
            mem[i] = h;
        end
        // directed prefix: every long code, the code below them, a straddle
        mem[0] = 16'hE800; mem[1] = 16'h1234;   // R3 aligned long (11101)
        mem[2] = 16'hE7FF;                      // 11100: short
        mem[3] = 16'hF000; mem[4] = 16'hABCD;   // R4 straddle (11110)
        mem[5] = 16'hF800; mem[6] = 16'h5555;   // 11111 straddling again
        mem[7] = 16'h0001;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R8 out_valid after reset", 32'(out_valid), 32'd0);
        chk(out_addr == 32'h0, "R8 out_addr after reset", out_addr, 32'h0);

        fa = BASE; exp_pc = BASE;
        for (int c = 0; c < CYCLES; c++) begin
            @(negedge clk);
            redir = (c == 0) || (c > 40 && ($urandom % 40 == 0)) || (fa >= LIMIT);
            if (c == 0) tgt = BASE;
            else tgt = BASE + ($urandom % (2*MEMH - 128));
            redirect_valid = redir;
            redirect_addr  = redir ? tgt : 32'($urandom);
            fetch_valid = (c < 20) ? 1'b1 : ($urandom % 10 < 7);
            out_ready   = (c < 20) ? 1'b1 : ($urandom % 10 < 7);
            fetch_word  = fetch_valid ? {hw_at(fa + 2), hw_at(fa)} : 32'($urandom);
            #1;
            if (redir) begin
                chk(out_valid == 1'b0, "R6 no output on redirect", 32'(out_valid), 32'd0);
                chk(fetch_ready == 1'b1, "R6 word dropped on redirect", 32'(fetch_ready), 32'd1);
                exp_pc = tgt & ~32'd1;
                fa     = tgt & ~32'd3;
            end else begin
                e_is32 = is_long(hw_at(exp_pc));
                e_insn = e_is32 ? {hw_at(exp_pc), hw_at(exp_pc + 2)} : {16'h0, hw_at(exp_pc)};
                if (exp_pc == fa + 2) begin
                    e_valid = e_is32 ? 1'b0 : fetch_valid;
                    e_fr    = 1'b1;
                end else if (exp_pc == fa) begin
                    e_valid = fetch_valid;
                    e_fr    = e_is32;
                end else begin
                    e_valid = fetch_valid;
                    e_fr    = 1'b0;
                end
                chk(out_valid == e_valid, "R9 out_valid", 32'(out_valid), 32'(e_valid));
                if (out_ready && fetch_valid)
                    chk(fetch_ready == e_fr, "R9 fetch_ready", 32'(fetch_ready), 32'(e_fr));
                if (!out_ready)
                    chk(fetch_ready == 1'b0, "R7 stall fetch", 32'(fetch_ready), 32'd0);
                if (out_valid && e_valid) begin
                    chk(out_addr == exp_pc, "R5 address", out_addr, exp_pc);
                    chk(out_is32 == e_is32, "R1 length", 32'(out_is32), 32'(e_is32));
                    if (!e_is32)
                        chk(out_insn == e_insn, "R2 short insn", out_insn, e_insn);
                    else if (exp_pc[1] == 1'b0)
                        chk(out_insn == e_insn, "R3 aligned long insn", out_insn, e_insn);
                    else
                        chk(out_insn == e_insn, "R4 straddling long insn", out_insn, e_insn);
                    if (out_ready) exp_pc = exp_pc + (e_is32 ? 32'd4 : 32'd2);
                end
                if (fetch_valid && fetch_ready) fa = fa + 4;
            end
        end
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule